// File: doc/BRIEF.md
# Start-Bit Framed Serial Display Latch

This block receives display data over two wires, a serial clock and a serial data line, and drives 35 latched output bits. There is no load or enable line. A frame is a single '1' start bit followed by 35 data bits, and the block finds the end of the frame by itself. The serial shift register is cleared between frames. When the start bit has been shifted all the way to the top position, the 35 bits below it are copied into the output latches. This copy happens while the 36th serial clock is still high. In the low phase that follows, the shift register is wiped so the next frame begins from all zeros.

Both serial inputs come from another clock domain. Each passes through its own flop synchronizer into the fast system clock domain, and the serial clock's rising edges are detected in logic. A four-state controller sequences the transfer:

- `ST_SHIFT`: waits for the start bit to reach the top of the register while the serial clock is high. The `T_TOP_SEEN` transition leads to `ST_LOAD`.
- `ST_LOAD`: pulses the latch load for one system cycle. The `T_LOADED` transition leads to `ST_HOLD`.
- `ST_HOLD`: waits for the serial clock to go low. The `T_CLK_LOW` transition leads to `ST_CLEAR`.
- `ST_CLEAR`: pulses the register clear for one cycle. The `T_CLEARED` transition returns to `ST_SHIFT`.

A host blanks the outputs from any state by sending 36 zeros, then a '1', then 35 zeros.

Top module: `framed_serial_latch`

## Requirements
- R1: A serial bit is taken from `ser_data` on each rising (0-to-1) edge of `ser_clk`, after both inputs have passed through the synchronizer.
- R2: A complete frame is 36 serial clocks: a '1' start bit followed by 35 data bits. A frame updates `disp_out` once the 36th clock has arrived.
- R3: The update of `disp_out` takes effect while the 36th serial clock is still high, no more than 7 system cycles after its rising edge.
- R4: In the low phase after the 36th clock, the shift register is cleared. A following frame sent back to back is therefore received correctly.
- R5: The first data bit after the start bit appears on `disp_out[0]`, and data bit k appears on `disp_out[k-1]`. A '1' drives the output on and a '0' drives it off.
- R6: After fewer than 36 serial clocks, `disp_out` keeps its previous value and the partial bits stay in the register. Completing the remaining clocks then loads the whole frame.
- R7: Sending 36 zeros, then a '1', then 35 zeros leaves every bit of `disp_out` at 0, whatever the prior contents.
- R8: While `rst` is high at a `clk` edge, the shift register, the controller and `disp_out` are all cleared to zero.
- R9: Zeros clocked in before the start bit of a frame have no effect on the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Asynchronous serial clock; bits are taken on its rising edge |
| ser_data | input | 1 | Asynchronous serial data |
| disp_out | output | 35 | Latched display outputs; bit 0 is the first data bit of a frame |

## Verification
The bench builds the block with its defaults: 35 data bits and a two-flop synchronizer. This makes a sweep over every output position practical. A single '1' is walked through all 35 data positions, and further dense and alternating patterns follow. The serial clock is slow compared with the system clock, so the bench can sample `disp_out` inside the high phase of the 36th clock and observe the load before the falling edge. The tests also cover a frame split across a pause, frames preceded by leading zeros, and the blanking sequence run after garbage has been left in the register.

// File: rtl/fsl_pkg.sv
package fsl_pkg;

    typedef enum logic [1:0] {
        ST_SHIFT = 2'd0,
        ST_LOAD  = 2'd1,
        ST_HOLD  = 2'd2,
        ST_CLEAR = 2'd3
    } fsl_state_t;

endpackage

// File: rtl/fsl_sync.sv
module fsl_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= async_in;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/fsl_edge.sv
module fsl_edge (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise,
    output logic high
);

    logic level_d;

    always_ff @(posedge clk) begin
        if (rst) level_d <= 1'b0;
        else     level_d <= level;
    end

    assign rise = level & ~level_d;
    assign high = level;

endmodule

// File: rtl/fsl_shifter.sv
module fsl_shifter #(
    parameter int DATA_BITS = 35,
    localparam int REG_W    = DATA_BITS + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             bit_in,
    input  logic             clear,
    output logic [REG_W-1:0] sreg,
    output logic             top
);

    always_ff @(posedge clk) begin
        if (rst || clear) sreg <= '0;
        else if (shift_en) sreg <= {sreg[REG_W-2:0], bit_in};
    end

    assign top = sreg[REG_W-1];

endmodule

// File: rtl/fsl_ctrl.sv
module fsl_ctrl
    import fsl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic top,
    input  logic clk_high,
    output logic load,
    output logic clear
);

    fsl_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_SHIFT;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        load     = 1'b0;
        clear    = 1'b0;
        unique case (state)
            ST_SHIFT: if (top && clk_high) state_nx = ST_LOAD;   // T_TOP_SEEN
            ST_LOAD: begin
                load     = 1'b1;
                state_nx = ST_HOLD;                              // T_LOADED
            end
            ST_HOLD:  if (!clk_high) state_nx = ST_CLEAR;        // T_CLK_LOW
            ST_CLEAR: begin
                clear    = 1'b1;
                state_nx = ST_SHIFT;                             // T_CLEARED
            end
            default:  state_nx = ST_SHIFT;
        endcase
    end

endmodule

// File: rtl/framed_serial_latch.sv
module framed_serial_latch #(
    parameter int DATA_BITS   = 35,
    parameter int SYNC_STAGES = 2,
    localparam int REG_W      = DATA_BITS + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ser_clk,
    input  logic                 ser_data,
    output logic [DATA_BITS-1:0] disp_out
);

    logic [1:0]       sync_pair;
    logic             sclk_rise;
    logic             sclk_high;
    logic [REG_W-1:0] sreg;
    logic             sreg_top;
    logic             load_pulse;
    logic             clear_pulse;

    fsl_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({ser_clk, ser_data}),
        .sync_out (sync_pair)
    );

    fsl_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (sync_pair[1]),
        .rise  (sclk_rise),
        .high  (sclk_high)
    );

    fsl_shifter #(.DATA_BITS(DATA_BITS)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (sclk_rise),
        .bit_in   (sync_pair[0]),
        .clear    (clear_pulse),
        .sreg     (sreg),
        .top      (sreg_top)
    );

    fsl_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .top      (sreg_top),
        .clk_high (sclk_high),
        .load     (load_pulse),
        .clear    (clear_pulse)
    );

    // Output latches: the bit shifted in first sits just below the start bit
    // and drives output 0.
    for (genvar i = 0; i < DATA_BITS; i++) begin : g_latch
        always_ff @(posedge clk) begin
            if (rst)             disp_out[i] <= 1'b0;
            else if (load_pulse) disp_out[i] <= sreg[DATA_BITS-1-i];
        end
    end

endmodule

// File: rtl/framed_serial_latch_chk.sv
module framed_serial_latch_chk #(
    parameter int DATA_BITS = 35,
    localparam int REG_W    = DATA_BITS + 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 load_pulse,
    input logic                 clear_pulse,
    input logic                 sclk_high,
    input logic [REG_W-1:0]     sreg,
    input logic [DATA_BITS-1:0] disp_out
);

    // R6: the outputs move only right after a load pulse
    p_out_only_on_load_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(disp_out) |-> $past(load_pulse));

    // R2: a load follows the start bit reaching the top position
    p_load_needs_start_r2: assert property (@(posedge clk) disable iff (rst)
        load_pulse |-> $past(sreg[REG_W-1]));

    // R3: the load is issued within the high phase of the serial clock
    p_load_in_high_r3: assert property (@(posedge clk) disable iff (rst)
        load_pulse |-> $past(sclk_high));

    // R4: a clear pulse empties the shift register
    p_clear_empties_r4: assert property (@(posedge clk) disable iff (rst)
        clear_pulse |=> (sreg == '0));

    // R4: the clear happens in the low phase of the serial clock
    p_clear_in_low_r4: assert property (@(posedge clk) disable iff (rst)
        clear_pulse |-> !$past(sclk_high));

    // R4: load and clear never coincide
    p_no_overlap_r4: assert property (@(posedge clk) disable iff (rst)
        !(load_pulse && clear_pulse));

endmodule

bind framed_serial_latch framed_serial_latch_chk #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .load_pulse  (load_pulse),
    .clear_pulse (clear_pulse),
    .sclk_high   (sclk_high),
    .sreg        (sreg),
    .disp_out    (disp_out)
);

// File: tb/framed_serial_latch_test.sv
module framed_serial_latch_test;

    localparam int NB = 35;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ser_clk = 1'b0;
    logic          ser_data = 1'b0;
    logic [NB-1:0] disp_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    framed_serial_latch uut (
        .clk      (clk),
        .rst      (rst),
        .ser_clk  (ser_clk),
        .ser_data (ser_data),
        .disp_out (disp_out)
    );

    task automatic check(input string req, input logic [NB-1:0] exp);
        checks++;
        if (disp_out !== exp) begin
            errors++;
            $display("FAIL %s: disp_out=%h expected=%h", req, disp_out, exp);
        end
    endtask

    // One serial bit. With probe set, disp_out is compared inside the high phase.
    task automatic send_bit(input logic b, input bit probe = 1'b0,
                            input logic [NB-1:0] exp = '0);
        @(negedge clk) ser_data = b;
        repeat (3) @(negedge clk);
        ser_clk = 1'b1;
        repeat (7) @(negedge clk);
        if (probe) check("R3", exp);
        @(negedge clk);
        ser_clk = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    // Start bit and 35 data bits; pattern bit 0 is sent first.
    task automatic send_frame(input logic [NB-1:0] pat, input bit probe = 1'b0);
        send_bit(1'b1);
        for (int j = 0; j < NB; j++)
            send_bit(pat[j], probe && (j == NB-1), pat);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R8", '0);

        // R5 / R2: walking one across every output position
        for (int k = 0; k < NB; k++) begin
            send_frame(NB'(1) << k, k == 0);
            check("R5", NB'(1) << k);
        end

        // R1 / R4: dense patterns sent back to back
        send_frame({NB{1'b1}}, 1'b1);
        check("R1", {NB{1'b1}});
        send_frame(35'h2AAAAAAAA);
        check("R4", 35'h2AAAAAAAA);
        send_frame(35'h555555555);
        check("R4", 35'h555555555);
        send_frame(35'h4C3A1F096);
        check("R1", 35'h4C3A1F096);

        // R6: partial frame leaves outputs unchanged, then completes
        send_bit(1'b1);
        for (int j = 0; j < 10; j++) send_bit(j[0]);
        repeat (40) @(negedge clk);
        check("R6", 35'h4C3A1F096);
        for (int j = 10; j < NB; j++) send_bit(j[0]);
        repeat (4) @(negedge clk);
        check("R6", 35'h2AAAAAAAA);

        // R9: leading zeros before the start bit
        for (int j = 0; j < 5; j++) send_bit(1'b0);
        send_frame(35'h13579BDF1);
        check("R9", 35'h13579BDF1);

        // R7: blanking sequence after garbage in the register
        send_frame({NB{1'b1}});
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        for (int j = 0; j < 36; j++) send_bit(1'b0);
        send_bit(1'b1);
        for (int j = 0; j < NB; j++) send_bit(1'b0);
        repeat (4) @(negedge clk);
        check("R7", '0);

        // R8: reset clears loaded outputs and the partial register
        send_frame(35'h7FFF0000F);
        check("R2", 35'h7FFF0000F);
        send_bit(1'b1); send_bit(1'b1);
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8", '0);
        send_frame(35'h000000301);
        check("R8", 35'h000000301);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule